// File: doc/BRIEF.md
# Indirect Auto-Increment Register Port

This block gives a host two byte-wide locations through which it reaches a bank of twenty-six 8-bit control registers of a peripheral bus controller. The host picks a location with `host_sel`. Location 0 is the pointer/status location. A write there loads the register pointer. A read there returns an auxiliary status byte. Location 1 is the data window, which reads or writes the register the pointer names. Every data-window access moves the pointer on by one. The pointer stops at the last register, number 25. A multi-byte field can therefore be streamed after a single pointer write. Examples are the 24-bit transfer count in registers 18 (high), 19 (middle) and 20 (low), or the command-block bytes in registers 3 to 14.

A write to the command register (number 24) while the block is idle hands that byte to an external command engine. The engine is modelled here only by a handshake. The block then runs a three-state sequencer:
- `ST_IDLE`: no command is running.
- `ST_CIP`: the command is being issued. This state lasts one cycle and drives `cmd_go`.
- `ST_RUN`: the command is executing, until the engine pulses `eng_done`.

Its transitions are:
- `T_ACCEPT`: `ST_IDLE` to `ST_CIP`, taken on an accepted command write.
- `T_ISSUE`: `ST_CIP` to `ST_RUN`, always taken.
- `T_FINISH`: `ST_RUN` to `ST_IDLE`, taken on `eng_done`.

On `T_FINISH` the engine's result byte goes into the status register (number 23) and the interrupt flag is raised. While a command is active, the host's access is limited to the data register and, outside `ST_CIP`, the command register.

Top module: `ixreg_port`

## Requirements
- R1: After reset every register, the pointer, the interrupt flag and the ignored-command flag are zero, and the sequencer is in `ST_IDLE`.
- R2: A read of location 0 returns {interrupt, command-ignored, busy, issuing, 0, 0, `eng_perr`, `eng_dbr`} from bit 7 down to bit 0. Such a read clears the command-ignored flag.
- R3: A write to location 0 loads the pointer from `host_wdata[4:0]`, at any time.
- R4: Each location-1 access advances the pointer by one if it is below 25. At 25 or above, the pointer holds its value. A blocked access still advances the pointer.
- R5: Registers 0 to 25 hold what the host wrote to them. `xfer_count` is {reg18, reg19, reg20}, with the high byte first.
- R6: `sync_offset` is register 17 bits 3:0, and `sync_period` is register 17 bits 6:4.
- R7: Pointer values 26 to 31 read as zero through location 1, and writes at those values are ignored.
- R8: A command-register write in `ST_IDLE` stores the byte. In the next cycle `cmd_go` is 1 for exactly one cycle, with `cmd_single` = bit 7 and `cmd_code` = bits 6:0. Busy and issuing both read 1 in that cycle, and after it busy alone reads 1.
- R9: While busy, location-1 accesses reach only register 25, and register 24 when the block is not issuing. Any other register reads as zero and ignores writes.
- R10: A command-register write while busy is dropped and sets the command-ignored flag.
- R11: When `eng_done` is high in `ST_RUN`, the next edge loads `eng_status` into register 23, sets the interrupt flag and returns the block to `ST_IDLE`.
- R12: A permitted read of register 23 clears the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cs | input | 1 | Host access strobe, one access per cycle |
| host_sel | input | 1 | 0 = pointer/status location, 1 = data window |
| host_we | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational |
| eng_dbr | input | 1 | Data buffer ready, shown in status bit 0 |
| eng_perr | input | 1 | Parity error, shown in status bit 1 |
| eng_done | input | 1 | Command engine completion pulse |
| eng_status | input | 8 | Completion code stored into register 23 |
| cmd_go | output | 1 | One-cycle command issue pulse |
| cmd_single | output | 1 | Single-byte qualifier of the command |
| cmd_code | output | 7 | Command code |
| xfer_count | output | 24 | Transfer count |
| sync_offset | output | 4 | Synchronous offset field |
| sync_period | output | 3 | Synchronous period field |

## Verification
Read data is combinational, so the bench checks `host_rdata` 1 ns after it drives a read, in the same cycle. The side effects of that access are due at the following rising edge:
- pointer step
- register write
- flag set or clear

The bench applies them to its model after that edge. `cmd_go`, the busy and issuing flags, `xfer_count` and the sync fields are registered state. The bench checks them 1 ns after the edge that follows the write or `eng_done`. The issue cycle is therefore visible in the very next access or check. `ST_RUN` follows one edge later.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;
    localparam int BYTE_W     = 8;
    localparam int REG_COUNT  = 26;
    localparam int PTR_W      = 5;
    localparam int IDX_LAST   = REG_COUNT - 1;
    localparam int IDX_SYNC   = 17;
    localparam int IDX_CNT_HI = 18;
    localparam int IDX_CNT_MD = 19;
    localparam int IDX_CNT_LO = 20;
    localparam int IDX_STATUS = 23;
    localparam int IDX_CMD    = 24;
    localparam int IDX_DATA   = 25;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CIP  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ixreg_ptr.sv
module ixreg_ptr
    import ixreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(IDX_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step && ptr < LAST) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ixreg_bank.sv
module ixreg_bank
    import ixreg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [PTR_W-1:0]                  wr_idx,
    input  logic [BYTE_W-1:0]                 wr_data,
    input  logic                              st_load,
    input  logic [BYTE_W-1:0]                 st_val,
    output logic [REG_COUNT-1:0][BYTE_W-1:0]  regs_q
);
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (i == IDX_STATUS) begin : g_status
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[i] <= '0;
                end else if (st_load) begin
                    regs_q[i] <= st_val;
                end else if (wr_en && wr_idx == PTR_W'(i)) begin
                    regs_q[i] <= wr_data;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[i] <= '0;
                end else if (wr_en && wr_idx == PTR_W'(i)) begin
                    regs_q[i] <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/ixreg_seq.sv
module ixreg_seq
    import ixreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       eng_done,
    output seq_state_e state,
    output logic       cmd_go,
    output logic       busy,
    output logic       issuing
);
    seq_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)   nxt = ST_CIP;   // T_ACCEPT
            ST_CIP:                nxt = ST_RUN;   // T_ISSUE
            ST_RUN:  if (eng_done) nxt = ST_IDLE;  // T_FINISH
            default:               nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_go  = (state == ST_CIP);
        busy    = (state != ST_IDLE);
        issuing = (state == ST_CIP);
    end
endmodule

// File: rtl/ixreg_port.sv
module ixreg_port
    import ixreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_cs,
    input  logic        host_sel,
    input  logic        host_we,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        eng_dbr,
    input  logic        eng_perr,
    input  logic        eng_done,
    input  logic [7:0]  eng_status,
    output logic        cmd_go,
    output logic        cmd_single,
    output logic [6:0]  cmd_code,
    output logic [23:0] xfer_count,
    output logic [3:0]  sync_offset,
    output logic [2:0]  sync_period
);
    localparam logic [PTR_W-1:0] P_LAST   = PTR_W'(IDX_LAST);
    localparam logic [PTR_W-1:0] P_STATUS = PTR_W'(IDX_STATUS);
    localparam logic [PTR_W-1:0] P_CMD    = PTR_W'(IDX_CMD);
    localparam logic [PTR_W-1:0] P_DATA   = PTR_W'(IDX_DATA);

    logic [PTR_W-1:0]                  ptr_q;
    logic [REG_COUNT-1:0][BYTE_W-1:0]  regs_q;
    seq_state_e                        state_q;
    logic                              busy, issuing;
    logic                              int_q, lci_q;

    logic data_acc, ptr_load, asr_rd, cmd_try, accept, finish;
    logic idx_valid, reg_open, bank_wr, status_rd;
    logic [BYTE_W-1:0] asr, win_rd;

    always_comb begin
        data_acc  = host_cs && host_sel;
        ptr_load  = host_cs && !host_sel && host_we;
        asr_rd    = host_cs && !host_sel && !host_we;
        idx_valid = (ptr_q <= P_LAST);
        reg_open  = idx_valid && (!busy || ptr_q == P_DATA ||
                                  (ptr_q == P_CMD && !issuing));
        cmd_try   = data_acc && host_we && ptr_q == P_CMD;
        accept    = cmd_try && !busy;
        bank_wr   = data_acc && host_we && reg_open && !(cmd_try && busy);
        status_rd = data_acc && !host_we && reg_open && ptr_q == P_STATUS;
        finish    = (state_q == ST_RUN) && eng_done;
    end

    ixreg_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (host_wdata[PTR_W-1:0]),
        .step     (data_acc),
        .ptr      (ptr_q)
    );

    ixreg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_wr),
        .wr_idx  (ptr_q),
        .wr_data (host_wdata),
        .st_load (finish),
        .st_val  (eng_status),
        .regs_q  (regs_q)
    );

    ixreg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .eng_done (eng_done),
        .state    (state_q),
        .cmd_go   (cmd_go),
        .busy     (busy),
        .issuing  (issuing)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= 1'b0;
            lci_q <= 1'b0;
        end else begin
            if (finish)         int_q <= 1'b1;
            else if (status_rd) int_q <= 1'b0;
            if (cmd_try && busy) lci_q <= 1'b1;
            else if (asr_rd)     lci_q <= 1'b0;
        end
    end

    always_comb begin
        asr    = {int_q, lci_q, busy, issuing, 2'b00, eng_perr, eng_dbr};
        win_rd = reg_open ? regs_q[ptr_q] : '0;
        host_rdata = host_sel ? win_rd : asr;
    end

    assign cmd_single  = regs_q[IDX_CMD][7];
    assign cmd_code    = regs_q[IDX_CMD][6:0];
    assign xfer_count  = {regs_q[IDX_CNT_HI], regs_q[IDX_CNT_MD], regs_q[IDX_CNT_LO]};
    assign sync_offset = regs_q[IDX_SYNC][3:0];
    assign sync_period = regs_q[IDX_SYNC][6:4];
endmodule

// File: rtl/ixreg_chk.sv
module ixreg_chk
    import ixreg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_cs,
    input logic             host_sel,
    input logic             host_we,
    input logic [7:0]       host_rdata,
    input logic             eng_done,
    input logic             cmd_go,
    input logic [PTR_W-1:0] ptr_q,
    input seq_state_e       state_q,
    input logic             int_q,
    input logic             lci_q
);
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_sel && ptr_q < 5'd25) |=> (ptr_q == $past(ptr_q) + 5'd1));

    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_sel && ptr_q >= 5'd25) |=> (ptr_q == $past(ptr_q)));

    p_high_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_sel && !host_we && ptr_q > 5'd25) |-> (host_rdata == 8'h00));

    p_go_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> (!cmd_go && state_q == ST_RUN));

    p_lci_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_sel && host_we && ptr_q == 5'd24 && state_q != ST_IDLE) |=> lci_q);

    p_int_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && eng_done) |=> (int_q && state_q == ST_IDLE));

    p_int_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_sel && !host_we && ptr_q == 5'd23 && state_q == ST_IDLE) |=> !int_q);
endmodule

bind ixreg_port ixreg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_cs    (host_cs),
    .host_sel   (host_sel),
    .host_we    (host_we),
    .host_rdata (host_rdata),
    .eng_done   (eng_done),
    .cmd_go     (cmd_go),
    .ptr_q      (ptr_q),
    .state_q    (state_q),
    .int_q      (int_q),
    .lci_q      (lci_q)
);

// File: tb/sim_ixreg_port.sv
module sim_ixreg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs = 1'b0, host_sel = 1'b0, host_we = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        eng_dbr = 1'b0, eng_perr = 1'b0, eng_done = 1'b0;
    logic [7:0]  eng_status = 8'h00;
    logic        cmd_go, cmd_single;
    logic [6:0]  cmd_code;
    logic [23:0] xfer_count;
    logic [3:0]  sync_offset;
    logic [2:0]  sync_period;

    int nchk = 0, nerr = 0;
    bit done_flag = 0;

    logic [7:0] mem [26];
    int  mptr = 0;
    int  mst  = 0;       // 0 idle, 1 issuing, 2 running
    bit  mint = 0, mlci = 0;

    always #10 clk = ~clk;

    ixreg_port u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit open_now();
        return (mptr <= 25) && (mst == 0 || mptr == 25 || (mptr == 24 && mst == 2));
    endfunction

    function automatic logic [7:0] exp_read(input bit sel);
        if (!sel) return {mint, mlci, mst != 0, mst == 1, 2'b00, eng_perr, eng_dbr};
        return open_now() ? mem[mptr] : 8'h00;
    endfunction

    task automatic step(input bit cs, input bit sel, input bit we, input logic [7:0] wd,
                        input bit dn, input logic [7:0] st, input string req);
        int nst;
        bit ok;
        @(negedge clk);
        host_cs = cs; host_sel = sel; host_we = we; host_wdata = wd;
        eng_done = dn; eng_status = st;
        #1;
        if (cs && !we) chk(req, host_rdata, exp_read(sel));
        ok = open_now();
        @(posedge clk);
        #1;
        host_cs = 1'b0; eng_done = 1'b0;
        nst = mst;
        if (mst == 1) nst = 2;
        if (mst == 2 && dn) begin nst = 0; mem[23] = st; mint = 1; end
        if (cs) begin
            if (!sel) begin
                if (we) mptr = int'(wd[4:0]);
                else    mlci = 0;
            end else begin
                if (we) begin
                    if (mptr == 24 && mst != 0) mlci = 1;
                    else if (ok) begin
                        mem[mptr] = wd;
                        if (mptr == 24) nst = 1;
                    end
                end else if (ok && mptr == 23) mint = 0;
                if (mptr < 25) mptr++;
            end
        end
        mst = nst;
    endtask

    task automatic wr_ptr(input int p, input string req);
        step(1, 0, 1, 8'(p), 0, 8'h00, req);
    endtask
    task automatic wr_dat(input logic [7:0] d, input string req);
        step(1, 1, 1, d, 0, 8'h00, req);
    endtask
    task automatic rd_dat(input string req);
        step(1, 1, 0, 8'h00, 0, 8'h00, req);
    endtask
    task automatic rd_asr(input string req);
        step(1, 0, 0, 8'h00, 0, 8'h00, req);
    endtask

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog actual=hung expected=finish");
        if (!done_flag) begin
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 26; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd_asr("R1 asr");
        rd_dat("R1 reg0");
        chk("R1 count", xfer_count, 24'h0);

        // R3 R5: stream transfer count
        wr_ptr(18, "R3");
        wr_dat(8'hAB, "R5"); wr_dat(8'hCD, "R5"); wr_dat(8'hEF, "R5");
        chk("R5 xfer_count", xfer_count, 24'hABCDEF);
        wr_ptr(18, "R3");
        rd_dat("R5 hi"); rd_dat("R5 mid"); rd_dat("R4 lo");
        wr_ptr(8'hE0 | 18, "R3 upper bits ignored");
        rd_dat("R3 reg18");

        // R6: sync fields
        wr_ptr(17, "R3");
        wr_dat(8'hDA, "R6");
        chk("R6 offset", sync_offset, 4'hA);
        chk("R6 period", sync_period, 3'h5);

        // R4: saturation at 25
        wr_ptr(25, "R4");
        wr_dat(8'h11, "R4"); wr_dat(8'h22, "R4");
        rd_dat("R4 sat"); rd_dat("R4 sat");
        wr_ptr(23, "R4");
        rd_dat("R4 r23"); rd_dat("R4 r24"); rd_dat("R4 r25");

        // R7: out-of-range numbers
        wr_ptr(28, "R7");
        wr_dat(8'h77, "R7");
        wr_ptr(28, "R7");
        rd_dat("R7 r28");
        wr_ptr(31, "R7");
        rd_dat("R7 r31");

        // R2: status inputs
        eng_perr = 1'b1; eng_dbr = 1'b1;
        rd_asr("R2 perr dbr");
        eng_perr = 1'b0;
        rd_asr("R2 dbr");
        eng_dbr = 1'b0;

        // R8: command issue
        wr_ptr(2, "R3"); wr_dat(8'h3C, "R5");
        wr_ptr(24, "R8");
        wr_dat(8'h93, "R8 write");
        chk("R8 cmd_go", cmd_go, 1'b1);
        chk("R8 single", cmd_single, 1'b1);
        chk("R8 code", cmd_code, 7'h13);
        rd_asr("R8 issuing");
        chk("R8 go drop", cmd_go, 1'b0);
        rd_asr("R8 running");

        // R9: restricted access while running
        wr_ptr(2, "R9");
        rd_dat("R9 blocked read");
        wr_ptr(2, "R9");
        wr_dat(8'h55, "R9 blocked write");
        wr_ptr(24, "R9");
        rd_dat("R9 cmd readable");
        wr_ptr(25, "R9");
        wr_dat(8'h66, "R9 data write");
        rd_dat("R9 data read");

        // R10: command write while busy
        wr_ptr(24, "R10");
        wr_dat(8'h01, "R10 dropped");
        chk("R10 code kept", cmd_code, 7'h13);
        rd_asr("R10 lci set");
        rd_asr("R2 lci cleared");

        // R11: finish
        step(0, 0, 0, 8'h00, 1, 8'h16, "R11");
        rd_asr("R11 int");
        wr_ptr(2, "R9");
        rd_dat("R9 reg2 kept");
        wr_ptr(23, "R11");
        rd_dat("R11 status value");
        rd_asr("R12 int cleared");

        // R8 again: command without single-byte bit
        wr_ptr(24, "R8");
        wr_dat(8'h20, "R8 write");
        chk("R8 single2", cmd_single, 1'b0);
        chk("R8 code2", cmd_code, 7'h20);
        step(0, 0, 0, 8'h00, 0, 8'h00, "R8");
        step(0, 0, 0, 8'h00, 1, 8'h85, "R11");
        rd_asr("R11 int2");

        // random idle traffic
        for (int i = 0; i < 500; i++) begin
            int r;
            r = int'($urandom_range(0, 3));
            case (r)
                0: wr_ptr(int'($urandom_range(0, 31)), "R3 rand");
                1: if (mptr == 24) rd_dat("R5 rand");
                   else wr_dat(8'($urandom), "R5 rand");
                2: rd_dat("R5 rand");
                default: rd_asr("R2 rand");
            endcase
        end
        chk("R5 count rand", xfer_count, {mem[18], mem[19], mem[20]});
        chk("R6 offset rand", sync_offset, mem[17][3:0]);
        chk("R6 period rand", sync_period, mem[17][6:4]);

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule